// File: doc/BRIEF.md
# Class-D Output Channel Control

This block is the digital control path of a two-channel 1-bit audio switching driver. On every rising edge of the master clock it registers two 1-bit pulse-width or pulse-density audio streams, a beep square-wave input and a beep loudness select. A two-bit mode word chooses which output stage receives the stream: the headphone stage, the line stage, or the beep stage. The mode word can also put every stage in standby. Only one stage is ever active. All other stages stay in high impedance.

Each tri-state output is modelled as a data bit plus an output-enable bit. A disabled stage drives its data bit to 0. An asynchronous supply-good flag from the regulated driver supply's level detector passes through a two-flop synchroniser. While the synchronised flag is low, every stage is held in high impedance, whatever the mode. All outputs come from registers, so an enable can only change on a master-clock rising edge and never partway through a sample.

Top module: `classd_out_ctrl`

## Requirements
- R1: While reset is high, after a clock edge every output-enable, every data output and the level output are 0.
- R2: With a stage enabled, its data outputs equal the audio inputs applied two clock edges earlier (one input register, one output register).
- R3: Mode word 2'b00 (standby) holds every output-enable at 0.
- R4: Mode word 2'b01 enables all line outputs. Headphone and beep enables stay 0.
- R5: Mode word 2'b10 enables all headphone outputs. Line and beep enables stay 0.
- R6: Mode word 2'b11 enables both beep pins. Pin 0 carries the registered beep input and pin 1 carries its complement.
- R7: While the synchronised supply-good flag is low, all enables are 0 in every mode. A change on the raw flag reaches the enables on the third clock edge.
- R8: Any output whose enable is 0 drives its data bit as 0.
- R9: At most one of the three stages has any enable set in any cycle.
- R10: The level output follows the level select input two edges later; 1 selects the louder beep level.
- R11: A mode word change reaches the stage enables on the second clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all sampling on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| audio_in | input | NCH | 1-bit audio streams, one per channel |
| tone_in | input | 1 | Beep square-wave input |
| level_hi_in | input | 1 | Beep level select, 1 = louder |
| mode_sel | input | 2 | Stage select: 00 standby, 01 line, 10 headphone, 11 beep |
| supply_ok_raw | input | 1 | Asynchronous driver-supply-above-threshold flag |
| hp_data | output | NCH | Headphone stage data |
| hp_oe | output | NCH | Headphone stage output enables |
| line_data | output | NCH | Line stage data |
| line_oe | output | NCH | Line stage output enables |
| tone_data | output | 2 | Beep pin data (pin 1 complementary) |
| tone_oe | output | 2 | Beep pin output enables |
| level_hi | output | 1 | Registered beep level select |

## Verification
On every cycle, the assertions check that the stages are mutually exclusive, that a low synchronised supply flag blanks all enables on the next edge, that enabled headphone data tracks the registered input, and that the beep pins are complementary. Only the bench's scenarios can show the exact latencies seen at the ports. These are two edges for data, mode and level, and three edges for the raw supply flag. The bench also sweeps every mode, supply, data and beep combination exhaustively against expected values it computes itself.

// File: rtl/classd_ctrl_pkg.sv
package classd_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'b00,
    MODE_LINE    = 2'b01,
    MODE_HP      = 2'b10,
    MODE_TONE    = 2'b11
  } drv_mode_e;

  typedef struct packed {
    logic hp;
    logic line;
    logic tone;
  } stage_en_t;
endpackage

// File: rtl/classd_sync.sv
module classd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/classd_mode_dec.sv
module classd_mode_dec
  import classd_ctrl_pkg::*;
(
  input  drv_mode_e mode,
  input  logic      supply_ok,
  output stage_en_t en
);
  always_comb begin
    en = '0;
    if (supply_ok) begin
      unique case (mode)
        MODE_LINE: en.line = 1'b1;
        MODE_HP:   en.hp   = 1'b1;
        MODE_TONE: en.tone = 1'b1;
        default:   en      = '0;
      endcase
    end
  end
endmodule

// File: rtl/classd_stage.sv
module classd_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i]  <= 1'b0;
        oe[i] <= 1'b0;
      end else begin
        oe[i] <= en;
        q[i]  <= en & d[i];
      end
    end
  end
endmodule

// File: rtl/classd_out_ctrl.sv
module classd_out_ctrl
  import classd_ctrl_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] audio_in,
  input  logic           tone_in,
  input  logic           level_hi_in,
  input  logic [1:0]     mode_sel,
  input  logic           supply_ok_raw,
  output logic [NCH-1:0] hp_data,
  output logic [NCH-1:0] hp_oe,
  output logic [NCH-1:0] line_data,
  output logic [NCH-1:0] line_oe,
  output logic [1:0]     tone_data,
  output logic [1:0]     tone_oe,
  output logic           level_hi
);
  localparam int TONE_PINS = 2;

  logic [NCH-1:0] audio_q;
  logic           tone_q;
  logic           level_q;
  drv_mode_e      mode_q;
  logic           supply_s;
  stage_en_t      en;
  logic [TONE_PINS-1:0] tone_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      audio_q  <= '0;
      tone_q   <= 1'b0;
      level_q  <= 1'b0;
      mode_q   <= MODE_STANDBY;
      level_hi <= 1'b0;
    end else begin
      audio_q  <= audio_in;
      tone_q   <= tone_in;
      level_q  <= level_hi_in;
      mode_q   <= drv_mode_e'(mode_sel);
      level_hi <= level_q;
    end
  end

  classd_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(supply_ok_raw), .q(supply_s)
  );

  classd_mode_dec u_dec (
    .mode(mode_q), .supply_ok(supply_s), .en(en)
  );

  assign tone_pair = {~tone_q, tone_q};

  classd_stage #(.W(NCH)) u_hp (
    .clk(clk), .rst(rst), .en(en.hp), .d(audio_q), .q(hp_data), .oe(hp_oe)
  );

  classd_stage #(.W(NCH)) u_line (
    .clk(clk), .rst(rst), .en(en.line), .d(audio_q), .q(line_data), .oe(line_oe)
  );

  classd_stage #(.W(TONE_PINS)) u_tone (
    .clk(clk), .rst(rst), .en(en.tone), .d(tone_pair), .q(tone_data), .oe(tone_oe)
  );

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (hp_oe == '0 && line_oe == '0 && tone_oe == '0 && level_hi == 1'b0))
    else $error("R1 reset state");

  // R7
  p_supply_blank_r7: assert property (@(posedge clk) disable iff (rst)
    !supply_s |=> (hp_oe == '0 && line_oe == '0 && tone_oe == '0))
    else $error("R7 supply gating");

  // R9
  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({|hp_oe, |line_oe, |tone_oe}) <= 1)
    else $error("R9 stage exclusion");

  // R2
  p_hp_follow_r2: assert property (@(posedge clk) disable iff (rst)
    en.hp |=> (hp_oe == {NCH{1'b1}} && hp_data == $past(audio_q)))
    else $error("R2 headphone data");

  // R6
  p_tone_pair_r6: assert property (@(posedge clk) disable iff (rst)
    (tone_oe == 2'b11) |-> (tone_data[1] == ~tone_data[0]))
    else $error("R6 beep pins");
endmodule

// File: tb/classd_out_ctrl_tb.sv
module classd_out_ctrl_tb;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic [NCH-1:0] audio_in;
  logic           tone_in;
  logic           level_hi_in;
  logic [1:0]     mode_sel;
  logic           supply_ok_raw;
  logic [NCH-1:0] hp_data, hp_oe, line_data, line_oe;
  logic [1:0]     tone_data, tone_oe;
  logic           level_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  classd_out_ctrl #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .audio_in(audio_in), .tone_in(tone_in),
    .level_hi_in(level_hi_in), .mode_sel(mode_sel), .supply_ok_raw(supply_ok_raw),
    .hp_data(hp_data), .hp_oe(hp_oe), .line_data(line_data), .line_oe(line_oe),
    .tone_data(tone_data), .tone_oe(tone_oe), .level_hi(level_hi)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; audio_in = '0; tone_in = 0; level_hi_in = 0;
    mode_sel = 2'b00; supply_ok_raw = 0;
    tick(3);
    // R1 reset state
    check("R1 oe", {hp_oe, line_oe, tone_oe}, 0);
    check("R1 data", {hp_data, line_data, tone_data, level_hi}, 0);
    rst = 1'b0;

    // Exhaustive sweep: mode x supply x audio x tone x level
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 4; a++)
          for (int t = 0; t < 2; t++) begin
            logic [NCH-1:0] e_hp_oe, e_ln_oe;
            logic [1:0] e_t_oe, e_t_d;
            mode_sel = m[1:0]; supply_ok_raw = s[0];
            audio_in = a[NCH-1:0]; tone_in = t[0]; level_hi_in = a[0] ^ t[0];
            tick(4);
            e_hp_oe = (m == 2 && s == 1) ? '1 : '0;
            e_ln_oe = (m == 1 && s == 1) ? '1 : '0;
            e_t_oe  = (m == 3 && s == 1) ? 2'b11 : 2'b00;
            e_t_d   = e_t_oe & {~t[0], t[0]};
            // R3 R4 R5 R6 R7: enables per mode and supply
            check("R5 hp_oe", hp_oe, e_hp_oe);
            check("R4 line_oe", line_oe, e_ln_oe);
            check("R6 tone_oe", tone_oe, e_t_oe);
            if (m == 0) check("R3 standby", {hp_oe, line_oe, tone_oe}, 0);
            if (s == 0) check("R7 blank", {hp_oe, line_oe, tone_oe}, 0);
            // R2 R8: data follows input when on, zero when off
            check("R2/R8 hp_data", hp_data, a[NCH-1:0] & e_hp_oe);
            check("R2/R8 line_data", line_data, a[NCH-1:0] & e_ln_oe);
            check("R6 tone_data", tone_data, e_t_d);
            check("R9 exclusive", ($countones({|hp_oe, |line_oe, |tone_oe}) <= 1), 1);
            check("R10 level", level_hi, a[0] ^ t[0]);
          end

    // R2 data latency: two edges
    mode_sel = 2'b10; supply_ok_raw = 1; audio_in = 2'b10; level_hi_in = 0;
    tick(4);
    audio_in = 2'b01; level_hi_in = 1;
    tick(1);
    check("R2 lat1", hp_data, 2'b10);
    check("R10 lat1", level_hi, 0);
    tick(1);
    check("R2 lat2", hp_data, 2'b01);
    check("R10 lat2", level_hi, 1);

    // R11 mode change latency: two edges
    mode_sel = 2'b01;
    tick(1);
    check("R11 lat1 hp", hp_oe, 2'b11);
    tick(1);
    check("R11 lat2 hp", hp_oe, 2'b00);
    check("R11 lat2 line", line_oe, 2'b11);

    // R7 supply rise/fall latency: three edges
    supply_ok_raw = 0;
    tick(2);
    check("R7 fall2", line_oe, 2'b11);
    tick(1);
    check("R7 fall3", line_oe, 2'b00);
    supply_ok_raw = 1;
    tick(2);
    check("R7 rise2", line_oe, 2'b00);
    tick(1);
    check("R7 rise3", line_oe, 2'b11);
    check("R8 line_data", line_data, 2'b01);

    // R1 reset during activity
    rst = 1;
    tick(1);
    check("R1 midrun", {hp_oe, line_oe, tone_oe, line_data, level_hi}, 0);
    rst = 0;
    tick(1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule